// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block holds one 64-bit model-specific control register. The register places a 16-byte window anywhere in a 16-bit I/O space and gates access to it. I/O cycles arrive on a 32-bit lane interface: a byte address, four lane enables, a direction and a strobe. When a cycle falls inside the enabled window, the decoder flags a hit. It then writes or reads a small byte-lane register file that stands for the power-management control bits held behind the window.

A second control bit arms a bus-side notification. Any full, aligned dword access that hits the window then raises a one-clock special-cycle request. The request carries a fixed active-low byte-enable code and a fixed value for address bits [4:3].

Clearing the enable bit blocks the window without changing its contents. Reads then return zero and writes are dropped. Setting the bit again exposes the same data. All results (register read data, hit flag, window read data and special-cycle request) are registered and appear one clock after the request is taken.

Top module: `io_window_decoder`

## Requirements
- R1: After synchronous reset, the control register reads zero, all 16 window bytes hold zero, and `io_hit`, `io_rdata` and `spc_req` are idle (0), with `spc_be_n` = 8'hFF.
- R2: The control register is selected when `cr_idx` equals parameter `CR_INDEX`. Its fields are: bit 0 is window enable, bit 1 is special-cycle arm, and bits [15:4] are the window base, i.e. I/O address bits [15:4]. Read data appears on `cr_rdata` one clock after `cr_rd`. A read at any other index returns zero, and a write at any other index changes nothing.
- R3: Bits [63:16] and [3:2] always read as zero, whatever was written to them.
- R4: One clock after a strobed I/O cycle, `io_hit` is 1 exactly when the enable bit is set and `io_addr[15:4]` equals the base field. Otherwise it is 0.
- R5: A window hit addresses dword slot `io_addr[3:2]`. Lane i is window byte 4*slot+i, carried on data bits [8i+7:8i]. A write stores only the lanes whose `io_be` bit is 1. A read returns all four bytes of the slot on `io_rdata` one clock later.
- R6: While the enable bit is 0, window reads return zero on `io_rdata` and window writes are dropped.
- R7: Clearing and then setting the enable bit leaves the window contents unchanged.
- R8: When the arm bit is set, a hit with `io_be` = 4'hF and `io_addr[1:0]` = 2'b00 raises `spc_req` for exactly one clock, one clock after the access. During that clock `spc_be_n` = 8'hBF and `spc_addr` = 2'b00. At all other times `spc_be_n` = 8'hFF.
- R9: No special cycle is requested for byte, word or misaligned accesses, for accesses outside the window, or while the arm bit or the enable bit is clear.
- R10: `io_rdata` is zero in every clock that does not follow a window read hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_idx | input | 32 | Register index for control-register access |
| cr_wr | input | 1 | Control-register write strobe |
| cr_rd | input | 1 | Control-register read strobe |
| cr_wdata | input | 64 | Control-register write data |
| cr_rdata | output | 64 | Control-register read data, registered |
| io_valid | input | 1 | I/O cycle strobe |
| io_write | input | 1 | 1 for an I/O write, 0 for a read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Active-high lane enables |
| io_wdata | input | 32 | I/O write data |
| io_hit | output | 1 | Registered window hit flag |
| io_rdata | output | 32 | Registered window read data |
| spc_req | output | 1 | One-clock special-cycle request |
| spc_be_n | output | 8 | Special-cycle active-low byte enables |
| spc_addr | output | 2 | Special-cycle address bits [4:3] |

## Verification
Every result is due exactly one clock after its request is captured. This holds for the register read data, the hit flag, the window read data and the special-cycle request. The bench therefore drives each request on the falling edge and samples one time unit after the next rising edge. It computes the expected hit, data and special-cycle values from its own model of the register fields and window bytes before the access. Each access is followed by an idle clock, which is sampled the same way to confirm the special-cycle request has dropped after a single clock. The sweeps cover addresses around each window edge, all sixteen lane-enable patterns with all four low-address offsets, and three base positions including both ends of the I/O space.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int EN_BIT   = 0;
  localparam int ARM_BIT  = 1;
  localparam logic [7:0] SPC_BE_N_ACTIVE = 8'hBF;
  localparam logic [7:0] SPC_BE_N_IDLE   = 8'hFF;
  localparam logic [1:0] SPC_ADDR_CODE   = 2'b00;

  typedef struct packed {
    logic hit;
    logic is_read;
    logic is_write;
    logic full_dword;
  } iowin_decode_t;
endpackage

// File: rtl/iowin_ctrl_reg.sv
module iowin_ctrl_reg #(
  parameter int REG_W    = 64,
  parameter int IDX_W    = 32,
  parameter logic [IDX_W-1:0] CR_INDEX = '0,
  parameter int BASE_LSB = 4,
  parameter int BASE_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [BASE_W-1:0] base,
  output logic              en,
  output logic              arm
);
  import iowin_pkg::*;

  logic             match;
  logic [REG_W-1:0] view;

  assign match = (sel_idx == CR_INDEX);

  // Only implemented fields are stored; reserved bits have no flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      en   <= 1'b0;
      arm  <= 1'b0;
    end else if (wr && match) begin
      base <= wdata[BASE_LSB +: BASE_W];
      en   <= wdata[EN_BIT];
      arm  <= wdata[ARM_BIT];
    end
  end

  always_comb begin
    view                     = '0;
    view[BASE_LSB +: BASE_W] = base;
    view[EN_BIT]             = en;
    view[ARM_BIT]            = arm;
  end

  always_ff @(posedge clk) begin
    if (rst)               rdata <= '0;
    else if (rd && match)  rdata <= view;
    else                   rdata <= '0;
  end
endmodule

// File: rtl/iowin_decode.sv
module iowin_decode #(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 4,
  parameter int BASE_W   = 12,
  parameter int LANES    = 4,
  parameter int SLOT_W   = 2
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES-1:0]     be,
  input  logic [BASE_W-1:0]    base,
  input  logic                 en,
  output iowin_pkg::iowin_decode_t dec,
  output logic [SLOT_W-1:0]    slot
);
  localparam int LANE_W = $clog2(LANES);

  logic in_range;
  logic aligned;

  assign in_range = (addr[ADDR_W-1:BASE_LSB] == base);

  generate
    if (LANE_W > 0) begin : g_align
      assign aligned = (addr[LANE_W-1:0] == '0);
    end else begin : g_noalign
      assign aligned = 1'b1;
    end
  endgenerate

  assign slot = addr[LANE_W +: SLOT_W];

  always_comb begin
    dec.hit        = valid && en && in_range;
    dec.is_read    = dec.hit && !write;
    dec.is_write   = dec.hit && write;
    dec.full_dword = (&be) && aligned;
  end
endmodule

// File: rtl/iowin_store.sv
module iowin_store #(
  parameter int LANES  = 4,
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               re,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [LANES-1:0]   be,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata
);
  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [SLOTS];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < SLOTS; s++) mem[s] <= '0;
        end else if (we && be[l]) begin
          mem[slot] <= wdata[8*l +: 8];
        end
      end

      always_ff @(posedge clk) begin
        if (rst)     rdata[8*l +: 8] <= '0;
        else if (re) rdata[8*l +: 8] <= mem[slot];
      end
    end
  endgenerate
endmodule

// File: rtl/iowin_spc.sv
module iowin_spc (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig,
  output logic       req,
  output logic [7:0] be_n,
  output logic [1:0] addr
);
  import iowin_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      be_n <= SPC_BE_N_IDLE;
    end else begin
      req  <= trig;
      be_n <= trig ? SPC_BE_N_ACTIVE : SPC_BE_N_IDLE;
    end
  end

  assign addr = SPC_ADDR_CODE;
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
  parameter int REG_W     = 64,
  parameter int IDX_W     = 32,
  parameter logic [IDX_W-1:0] CR_INDEX = 32'h0000_0A1C,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int WIN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  cr_idx,
  input  logic              cr_wr,
  input  logic              cr_rd,
  input  logic [REG_W-1:0]  cr_wdata,
  output logic [REG_W-1:0]  cr_rdata,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W/8-1:0] io_be,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              io_hit,
  output logic [DATA_W-1:0] io_rdata,
  output logic              spc_req,
  output logic [7:0]        spc_be_n,
  output logic [1:0]        spc_addr
);
  import iowin_pkg::*;

  localparam int LANES    = DATA_W / 8;
  localparam int SLOTS    = WIN_BYTES / LANES;
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BASE_LSB = $clog2(WIN_BYTES);
  localparam int BASE_W   = ADDR_W - BASE_LSB;

  logic [BASE_W-1:0] base;
  logic              en;
  logic              arm;
  iowin_decode_t     dec;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] store_rdata;
  logic              rd_hit_q;

  iowin_ctrl_reg #(
    .REG_W(REG_W), .IDX_W(IDX_W), .CR_INDEX(CR_INDEX),
    .BASE_LSB(BASE_LSB), .BASE_W(BASE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sel_idx(cr_idx), .wr(cr_wr), .rd(cr_rd),
    .wdata(cr_wdata), .rdata(cr_rdata), .base(base), .en(en), .arm(arm)
  );

  iowin_decode #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .BASE_W(BASE_W),
    .LANES(LANES), .SLOT_W(SLOT_W)
  ) u_dec (
    .valid(io_valid), .write(io_write), .addr(io_addr), .be(io_be),
    .base(base), .en(en), .dec(dec), .slot(slot)
  );

  iowin_store #(
    .LANES(LANES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst(rst), .we(dec.is_write), .re(dec.is_read),
    .slot(slot), .be(io_be), .wdata(io_wdata), .rdata(store_rdata)
  );

  iowin_spc u_spc (
    .clk(clk), .rst(rst), .trig(dec.hit && dec.full_dword && arm),
    .req(spc_req), .be_n(spc_be_n), .addr(spc_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_hit   <= 1'b0;
      rd_hit_q <= 1'b0;
    end else begin
      io_hit   <= dec.hit;
      rd_hit_q <= dec.is_read;
    end
  end

  assign io_rdata = rd_hit_q ? store_rdata : '0;
endmodule

// File: rtl/iowin_chk.sv
module iowin_chk #(
  parameter int REG_W  = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  cr_rdata,
  input logic              io_valid,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W/8-1:0] io_be,
  input logic              io_hit,
  input logic [DATA_W-1:0] io_rdata,
  input logic              spc_req,
  input logic [7:0]        spc_be_n,
  input logic [1:0]        spc_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cr_rdata == '0 && !io_hit && !spc_req && io_rdata == '0));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (cr_rdata[REG_W-1:16] == '0 && cr_rdata[3:2] == 2'b00));

  assert_hit_needs_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    io_hit |-> $past(io_valid));

  assert_spc_pattern_R8: assert property (@(posedge clk) disable iff (rst)
    spc_req |-> (spc_be_n == 8'hBF && spc_addr == 2'b00));

  assert_spc_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !spc_req |-> (spc_be_n == 8'hFF));

  assert_spc_dword_only_R9: assert property (@(posedge clk) disable iff (rst)
    spc_req |-> (io_hit && &($past(io_be)) && $past(io_addr[1:0]) == 2'b00));

  assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!io_hit || $past(io_write)) |-> (io_rdata == '0));
endmodule

bind io_window_decoder iowin_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .cr_rdata(cr_rdata), .io_valid(io_valid),
  .io_write(io_write), .io_addr(io_addr), .io_be(io_be), .io_hit(io_hit),
  .io_rdata(io_rdata), .spc_req(spc_req), .spc_be_n(spc_be_n),
  .spc_addr(spc_addr)
);

// File: tb/io_window_decoder_tb.sv
module io_window_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDX = 32'h0000_0A1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cr_idx = '0;
  logic        cr_wr = 1'b0, cr_rd = 1'b0;
  logic [63:0] cr_wdata = '0, cr_rdata;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic        io_hit, spc_req;
  logic [7:0]  spc_be_n;
  logic [1:0]  spc_addr;

  int checks = 0;
  int errors = 0;

  logic [7:0]  model [16];
  logic [11:0] m_base = '0;
  logic        m_en = 1'b0, m_arm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_window_decoder #(.CR_INDEX(IDX)) u_dut (
    .clk(clk), .rst(rst), .cr_idx(cr_idx), .cr_wr(cr_wr), .cr_rd(cr_rd),
    .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .io_valid(io_valid),
    .io_write(io_write), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_hit(io_hit), .io_rdata(io_rdata),
    .spc_req(spc_req), .spc_be_n(spc_be_n), .spc_addr(spc_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cr_write(input logic [31:0] idx, input logic [63:0] d);
    @(negedge clk);
    cr_idx = idx; cr_wdata = d; cr_wr = 1'b1;
    @(negedge clk);
    cr_wr = 1'b0;
    if (idx == IDX) begin
      m_base = d[15:4]; m_arm = d[1]; m_en = d[0];
    end
  endtask

  task automatic cr_check(input logic [31:0] idx, input logic [63:0] exp, input string tag);
    @(negedge clk);
    cr_idx = idx; cr_rd = 1'b1;
    @(posedge clk); #1;
    chk(tag, cr_rdata, exp);
    @(negedge clk);
    cr_rd = 1'b0;
  endtask

  function automatic logic [63:0] cr_view();
    return {48'h0, m_base, 2'b00, m_arm, m_en};
  endfunction

  task automatic io_op(input logic [15:0] a, input logic [3:0] be, input logic wr,
                       input logic [31:0] wd, input string tg);
    logic        hit_e, spc_e;
    logic [31:0] rd_e;
    string       rtag, stag;
    hit_e = m_en && (a[15:4] == m_base);
    spc_e = hit_e && m_arm && (be == 4'hF) && (a[1:0] == 2'b00);
    rd_e  = (hit_e && !wr) ? {model[{a[3:2],2'd3}], model[{a[3:2],2'd2}],
                              model[{a[3:2],2'd1}], model[{a[3:2],2'd0}]} : 32'h0;
    rtag  = (tg != "") ? tg : (!m_en ? "R6" : (wr ? "R10" : "R5"));
    stag  = spc_e ? "R8" : "R9";
    @(negedge clk);
    io_addr = a; io_be = be; io_write = wr; io_wdata = wd; io_valid = 1'b1;
    @(posedge clk); #1;
    chk("R4 hit", {63'h0, io_hit}, {63'h0, hit_e});
    chk(rtag, {32'h0, io_rdata}, {32'h0, rd_e});
    chk(stag, {53'h0, spc_req, spc_be_n, spc_addr}, {53'h0, spc_e, spc_e ? 8'hBF : 8'hFF, 2'b00});
    if (hit_e && wr)
      for (int i = 0; i < 4; i++)
        if (be[i]) model[{a[3:2], 2'(i)}] = wd[8*i +: 8];
    @(negedge clk);
    io_valid = 1'b0;
    @(posedge clk); #1;
    chk("R8 single pulse", {63'h0, spc_req}, 64'h0);
    chk("R10 idle rdata", {32'h0, io_rdata}, 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] bases [3];
    bases[0] = 12'h12A; bases[1] = 12'h000; bases[2] = 12'hFFF;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 cr_rdata", cr_rdata, 64'h0);
    chk("R1 outputs", {31'h0, io_hit, spc_req, io_rdata}, 64'h0);
    chk("R1 spc_be_n", {56'h0, spc_be_n}, 64'hFF);
    cr_check(IDX, 64'h0, "R1 reg");

    // R3: reserved bits read back zero
    cr_write(IDX, 64'hFFFF_FFFF_FFFF_FFFF);
    cr_check(IDX, 64'h0000_0000_0000_FFF3, "R3 reserved");
    // R2: wrong index ignored for writes, reads zero
    cr_write(IDX ^ 32'h1, 64'h0);
    cr_check(IDX, 64'h0000_0000_0000_FFF3, "R2 wrong-index write");
    cr_check(IDX + 32'h10, 64'h0, "R2 wrong-index read");

    // R1: window empty after reset, read with enable on
    cr_write(IDX, 64'h0000_0000_0000_0001);
    cr_check(IDX, cr_view(), "R2 fields");
    for (int s = 0; s < 4; s++) io_op(16'(s * 4), 4'hF, 1'b0, 32'h0, "R1 window");

    for (int b = 0; b < 3; b++) begin
      logic [15:0] w0;
      cr_write(IDX, {48'h0, bases[b], 4'b0001});
      cr_check(IDX, cr_view(), "R2 fields");
      w0 = {bases[b], 4'h0};
      // address sweep across both window edges
      for (int off = -8; off < 24; off++)
        io_op(w0 + 16'(off), 4'hF, 1'b1, {8'(b), 8'(off), 8'(~off), 8'hA5 ^ 8'(off)}, "");
      for (int s = 0; s < 4; s++) io_op(w0 + 16'(s * 4), 4'hF, 1'b0, 32'h0, "");
      // all lane enables, all low offsets, special cycles armed
      cr_write(IDX, {48'h0, bases[b], 4'b0011});
      for (int be = 0; be < 16; be++)
        for (int lo = 0; lo < 4; lo++) begin
          io_op(w0 + 16'((be % 4) * 4 + lo), 4'(be), 1'(lo % 2),
                32'(be * 32'h0101_0101 + lo), "");
        end
      io_op(w0 - 16'd4, 4'hF, 1'b0, 32'h0, "");
      io_op(w0 + 16'd16, 4'hF, 1'b0, 32'h0, "");
      // arm cleared: no special cycle
      cr_write(IDX, {48'h0, bases[b], 4'b0001});
      io_op(w0 + 16'd8, 4'hF, 1'b0, 32'h0, "");
      // enable cleared: reads zero, writes dropped
      cr_write(IDX, {48'h0, bases[b], 4'b0010});
      for (int s = 0; s < 4; s++) begin
        io_op(w0 + 16'(s * 4), 4'hF, 1'b1, 32'hDEAD_BEEF, "");
        io_op(w0 + 16'(s * 4), 4'hF, 1'b0, 32'h0, "");
      end
      // re-enable: contents preserved
      cr_write(IDX, {48'h0, bases[b], 4'b0001});
      for (int s = 0; s < 4; s++) io_op(w0 + 16'(s * 4), 4'hF, 1'b0, 32'h0, "R7");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule